// File: doc/BRIEF.md
# Windowed Watchdog with Clock Monitor

This supervisor watches a piece of software that must write a service byte at regular intervals. Time is counted in instruction cycles, which arrive as a one-clock enable pulse (`cyc_tick`). A service write is accepted only when it falls inside a window. The window opens a fixed number of cycles after the previous restart and closes at an upper limit chosen by two bits of the service byte. A write that comes too early is a fault. So is a window that closes with no write at all.

A second supervisor takes in a clock-failure indication from an external frequency sensor. It holds the error output low for as long as that indication is high. Once the indication clears, it keeps the output low for a fixed number of instruction cycles before releasing it. Faults from both supervisors share one active-low error pin. The block also reports the lower and upper window limits currently in force, so the surrounding logic can see the active window.

Top module: `wdw_supervisor`

## Requirements
- R1: While `rst_n` is low, `err_n` is high, `win_hi` reads 65536 and the window counter is cleared. After `rst_n` is released, both supervisors are active at once, with no enable step needed.
- R2: A service write made when fewer than 2048 cycles have elapsed since the last restart drives `err_n` low for exactly one clock. The counter restarts and the selected window is left unchanged.
- R3: A service write made when the elapsed count lies between 2048 and the selected upper limit, both bounds included, raises no error and restarts the count from zero.
- R4: On an accepted service, bits 7:6 of `svc_data` set the upper limit: 00 gives 8192, 01 gives 16384, 10 gives 32768 and 11 gives 65536. The other bits are ignored. `win_hi` shows the new limit from the next clock.
- R5: If the count equals the upper limit, a tick arrives and no service write is made, then `err_n` goes low for exactly one clock and the count restarts.
- R6: While `clk_fail` is high, `err_n` is low from the clock after `clk_fail` is first sampled high.
- R7: After `clk_fail` is sampled low, `err_n` stays low for exactly 16 further cycle ticks and then returns high. Clocks without a tick do not advance this delay.
- R8: The elapsed count advances only on clocks where `cyc_tick` is high. With no ticks, no late fault can occur and an early service is still detected.
- R9: Watchdog faults and clock faults are ORed onto `err_n`. A watchdog fault during a clock failure does not shorten the clock-failure hold.
- R10: `win_lo` always reads 2048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse per instruction cycle |
| svc_wr | input | 1 | Service-register write strobe |
| svc_data | input | 8 | Service byte; bits 7:6 select the window |
| clk_fail | input | 1 | Clock-frequency fault indication, synchronous to clk |
| err_n | output | 1 | Active-low combined fault output |
| win_lo | output | 17 | Lower window limit in cycles |
| win_hi | output | 17 | Selected upper window limit in cycles |

## Verification
The assertions check these rules on every cycle:
- the elapsed count never exceeds the selected limit;
- any write restarts the count;
- the window selection changes only on a write;
- the count stays put without a tick;
- a clock failure pulls the output low on the next clock;
- the release always comes exactly the set number of ticks after the failure clears.

Only the bench scenarios can show the rest:
- the exact cycle at which the window opens and closes for each of the four selections;
- that an early write keeps the old window;
- that a late fault fires once and re-arms;
- how both fault sources overlap on the single pin.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

   // Upper-limit selector: each step doubles the base limit.
   typedef enum logic [1:0] {
      WIN_X1 = 2'b00,
      WIN_X2 = 2'b01,
      WIN_X4 = 2'b10,
      WIN_X8 = 2'b11
   } win_sel_e;

   // Selection loaded by reset: the widest window.
   localparam win_sel_e WIN_RESET_SEL = WIN_X8;

   // Number of distinct window selections.
   localparam int unsigned WIN_CHOICES = 4;

endpackage

// File: rtl/wdw_window_timer.sv
module wdw_window_timer
   import wdw_pkg::*;
#(
   parameter int unsigned LOWER_CYC = 2048,
   parameter int unsigned UPPER_MIN = 8192,
   parameter int unsigned SEL_MSB   = 7,
   parameter int unsigned CNT_W     = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_tick,
   input  logic             svc_wr,
   input  logic [7:0]       svc_data,
   output logic             wd_err,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] upper
);

   localparam logic [CNT_W-1:0] LOWER_LIM = CNT_W'(LOWER_CYC);

   win_sel_e         sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic             err_q;
   logic [CNT_W-1:0] lim [WIN_CHOICES];
   logic             early;
   logic             late;
   logic             unused_data;

   // One limit per selection code, each twice the previous one.
   for (genvar g = 0; g < int'(WIN_CHOICES); g++) begin : g_limits
      localparam int unsigned LIM_G = UPPER_MIN << g;
      assign lim[g] = CNT_W'(LIM_G);
   end

   assign upper       = lim[sel_q];
   assign early       = svc_wr && (cnt_q < LOWER_LIM);
   assign late        = cyc_tick && !svc_wr && (cnt_q == upper);
   assign unused_data = ^svc_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sel_q <= WIN_RESET_SEL;
         err_q <= 1'b0;
      end else begin
         err_q <= early || late;
         if (svc_wr) begin
            cnt_q <= '0;
            if (!early) begin
               sel_q <= win_sel_e'(svc_data[SEL_MSB -: 2]);
            end
         end else if (cyc_tick) begin
            if (late) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign wd_err = err_q;
   assign cnt    = cnt_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= upper);                                                      // R5
   AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      svc_wr |=> (cnt_q == '0));                                            // R3
   AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !svc_wr |=> $stable(sel_q));                                          // R4
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!svc_wr && !cyc_tick) |=> $stable(cnt_q));                           // R8

endmodule

// File: rtl/wdw_clk_monitor.sv
module wdw_clk_monitor #(
   parameter int unsigned RELEASE_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_tick,
   input  logic clk_fail,
   output logic cm_err
);

   localparam int unsigned RW = $clog2(RELEASE_CYC);
   localparam int unsigned QW = $clog2(RELEASE_CYC + 2);
   localparam logic [RW-1:0] REL_LAST = RW'(RELEASE_CYC - 1);
   localparam logic [QW-1:0] Q_REL    = QW'(RELEASE_CYC);
   localparam logic [QW-1:0] Q_MAX    = QW'(RELEASE_CYC + 1);

   logic          hold_q;
   logic [RW-1:0] rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
         rel_q  <= '0;
      end else if (clk_fail) begin
         hold_q <= 1'b1;
         rel_q  <= '0;
      end else if (hold_q && cyc_tick) begin
         if (rel_q == REL_LAST) begin
            hold_q <= 1'b0;
            rel_q  <= '0;
         end else begin
            rel_q  <= rel_q + 1'b1;
         end
      end
   end

   assign cm_err = hold_q;

   // Independent count of ticks since the fault cleared, used only by the checks.
   logic [QW-1:0] quiet_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q <= '0;
      end else if (clk_fail) begin
         quiet_q <= '0;
      end else if (cyc_tick && quiet_q != Q_MAX) begin
         quiet_q <= quiet_q + 1'b1;
      end
   end

   AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      clk_fail |=> hold_q);                                                 // R6
   AST_RELEASE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_q) |-> (quiet_q == Q_REL));                                // R7

endmodule

// File: rtl/wdw_supervisor.sv
module wdw_supervisor #(
   parameter int unsigned LOWER_CYC   = 2048,
   parameter int unsigned UPPER_MIN   = 8192,
   parameter int unsigned SEL_MSB     = 7,
   parameter int unsigned RELEASE_CYC = 16,
   parameter bit          OUT_REG     = 1'b0,
   localparam int unsigned CNT_W      = $clog2(UPPER_MIN * 8 + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_tick,
   input  logic             svc_wr,
   input  logic [7:0]       svc_data,
   input  logic             clk_fail,
   output logic             err_n,
   output logic [CNT_W-1:0] win_lo,
   output logic [CNT_W-1:0] win_hi
);

   // Parameter checks, evaluated at elaboration.
   if (RELEASE_CYC < 16 || RELEASE_CYC > 32) begin : g_bad_release
      $error("RELEASE_CYC must lie in 16..32");
   end
   if (LOWER_CYC == 0 || LOWER_CYC >= UPPER_MIN) begin : g_bad_lower
      $error("LOWER_CYC must be non-zero and below UPPER_MIN");
   end
   if (SEL_MSB < 1 || SEL_MSB > 7) begin : g_bad_sel
      $error("SEL_MSB must address a two-bit field inside the byte");
   end

   logic             wd_err;
   logic             cm_err;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] upper;

   wdw_window_timer #(
      .LOWER_CYC (LOWER_CYC),
      .UPPER_MIN (UPPER_MIN),
      .SEL_MSB   (SEL_MSB),
      .CNT_W     (CNT_W)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_tick (cyc_tick),
      .svc_wr   (svc_wr),
      .svc_data (svc_data),
      .wd_err   (wd_err),
      .cnt      (cnt),
      .upper    (upper)
   );

   wdw_clk_monitor #(
      .RELEASE_CYC (RELEASE_CYC)
   ) i_clkmon (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_tick (cyc_tick),
      .clk_fail (clk_fail),
      .cm_err   (cm_err)
   );

   assign win_lo = CNT_W'(LOWER_CYC);
   assign win_hi = upper;

   if (OUT_REG) begin : g_out_reg
      logic err_n_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err_n_q <= 1'b1;
         else        err_n_q <= !(wd_err || cm_err);
      end
      assign err_n = err_n_q;
   end else begin : g_out_comb
      assign err_n = !(wd_err || cm_err);

      AST_FAIL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
         clk_fail |=> !err_n);                                              // R6
      AST_LATE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
         (cyc_tick && !svc_wr && cnt == upper) |=> !err_n);                 // R5
   end

endmodule

// File: tb/test_wdw_supervisor.sv
module test_wdw_supervisor;

   localparam time CLK_PERIOD = 10;
   localparam int  ROWS       = 7;

   // Per row: gap (cycles since restart), byte written, expected err_n, expected win_hi.
   localparam int unsigned GAPS    [ROWS] = '{3000, 100, 2048, 16384, 2047, 20000, 8191};
   localparam logic [7:0]  DATS    [ROWS] = '{8'h00, 8'hC0, 8'h40, 8'h80, 8'h00, 8'hC0, 8'h3F};
   localparam logic        EXP_ERR [ROWS] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};
   localparam int unsigned EXP_HI  [ROWS] = '{8192, 8192, 16384, 32768, 32768, 65536, 8192};

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cyc_tick;
   logic        svc_wr;
   logic [7:0]  svc_data;
   logic        clk_fail;
   logic        err_n;
   logic [16:0] win_lo;
   logic [16:0] win_hi;

   int checks = 0;
   int errors = 0;

   wdw_supervisor i_wdw_supervisor (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_tick (cyc_tick),
      .svc_wr   (svc_wr),
      .svc_data (svc_data),
      .clk_fail (clk_fail),
      .err_n    (err_n),
      .win_lo   (win_lo),
      .win_hi   (win_hi)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle(input int unsigned n);
      repeat (n) @(negedge clk);
   endtask

   // Idle n cycles and return how many of them showed err_n low.
   task automatic idle_watch(input int unsigned n, output int unsigned lows);
      lows = 0;
      for (int unsigned k = 0; k < n; k++) begin
         @(negedge clk);
         if (err_n !== 1'b1) lows++;
      end
   endtask

   // Write strobe for one clock; returns at the negedge after the sampling edge.
   task automatic service(input logic [7:0] d);
      svc_wr   = 1'b1;
      svc_data = d;
      @(negedge clk);
      svc_wr   = 1'b0;
      svc_data = 8'h00;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int unsigned lows;
      rst_n    = 1'b0;
      cyc_tick = 1'b1;
      svc_wr   = 1'b0;
      svc_data = 8'h00;
      clk_fail = 1'b0;
      idle(4);
      // R1 and R10: reset state
      chk("R1 err_n in reset", err_n, 1);
      chk("R1 win_hi in reset", win_hi, 65536);
      chk("R10 win_lo", win_lo, 2048);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: early, accepted and boundary writes (R2 R3 R4)
      for (int i = 0; i < ROWS; i++) begin
         idle(GAPS[i] - 1);
         service(DATS[i]);
         chk(EXP_ERR[i] ? "R3 accepted write" : "R2 early write", err_n, EXP_ERR[i]);
         chk("R4 window select", win_hi, EXP_HI[i]);
         @(negedge clk);
         chk("R2 one-clock pulse", err_n, 1);
      end
      chk("R10 win_lo steady", win_lo, 2048);

      // R5: late fault with 8192 window
      idle(8191);
      chk("R5 before limit", err_n, 1);
      @(negedge clk);
      chk("R5 late fault", err_n, 0);
      @(negedge clk);
      chk("R5 late pulse ends", err_n, 1);

      // R8: no ticks, count frozen, early write still caught
      cyc_tick = 1'b0;
      idle_watch(10000, lows);
      chk("R8 no late without ticks", lows, 0);
      service(8'hC0);
      chk("R8 frozen count early", err_n, 0);
      chk("R8 window kept", win_hi, 8192);
      cyc_tick = 1'b1;
      @(negedge clk);

      // R6 and R7: clock failure and release delay
      clk_fail = 1'b1;
      @(negedge clk);
      chk("R6 fail drives low", err_n, 0);
      idle_watch(40, lows);
      chk("R6 low while failing", lows, 40);
      clk_fail = 1'b0;
      idle(15);
      chk("R7 still held", err_n, 0);
      @(negedge clk);
      chk("R7 released after 16", err_n, 1);

      // R9: watchdog fault inside a clock failure
      clk_fail = 1'b1;
      @(negedge clk);
      service(8'h00);
      chk("R9 both sources low", err_n, 0);
      @(negedge clk);
      chk("R9 held by clock fault", err_n, 0);
      clk_fail = 1'b0;
      idle(15);
      chk("R9 release not shortened", err_n, 0);
      @(negedge clk);
      chk("R9 release", err_n, 1);

      // R7: release counts ticks only
      clk_fail = 1'b1;
      @(negedge clk);
      clk_fail = 1'b0;
      cyc_tick = 1'b0;
      idle(40);
      chk("R7 no tick no release", err_n, 0);
      cyc_tick = 1'b1;
      idle(15);
      chk("R7 ticks 15", err_n, 0);
      @(negedge clk);
      chk("R7 ticks 16", err_n, 1);

      // R1: reset during a clock failure, then armed again
      service(8'h00);
      @(negedge clk);
      clk_fail = 1'b1;
      @(negedge clk);
      chk("R6 low before reset", err_n, 0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 held off in reset", err_n, 1);
      chk("R1 window restored", win_hi, 65536);
      clk_fail = 1'b0;
      rst_n    = 1'b1;
      idle(100);
      service(8'h00);
      chk("R1 armed after reset", err_n, 0);
      chk("R1 window after early", win_hi, 65536);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule